// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible face of a serial port. It sits on a simple 32-bit bus with separate read and write strobes and a byte address inside a 4 KB window. It decodes the word index of each access into a small set of registers. These are a data port, a latched receive error status, a flag word, four line and baud configuration words, a control word, a FIFO level selector, an interrupt mask, raw and masked interrupt status, a write-one-to-clear interrupt register and a DMA control word. The top eight words of the window return a fixed identification byte each.

Receive data does not live here. The receive FIFO block presents its head entry (eight data bits and four error bits) together with empty and full flags, and it raises a one-cycle event when its fill level crosses the threshold or falls back below it. A bus read of the data word returns the head entry and pops the FIFO in the same cycle. A bus write of the data word hands the low byte to the transmitter as a one-cycle `tx_valid` pulse. The transmit sink has no back-pressure: it must take every pulse, and the pulses may come on consecutive cycles.

Interrupts come from two raw sources, transmit and receive. Each raw bit sets only on its own event. Software clears a raw bit by writing a 1 in that position. The `irq` output is high whenever any raw bit is also enabled in the mask.

Top module: `uart_regif`

## Requirements
- R1: After reset, the FIFO level word reads 0x12 and the control word reads 0x300. Raw status and mask read 0, `irq` is low, and with `rx_empty`=1 and `rx_full`=0 the flag word reads 0x90.
- R2: The configuration words read back what was last written, cut to their widths. The widths are: byte 0x20 8 bits, 0x24 16 bits, 0x28 6 bits, 0x2C 8 bits, 0x30 16 bits, 0x34 6 bits, mask at 0x38 11 bits, DMA control at 0x48 3 bits.
- R3: A write to byte 0x00 drives `tx_byte` = wdata[7:0] with `tx_valid` high for exactly the next cycle, and it sets raw bit 5 (transmit). Back-to-back writes give back-to-back pulses.
- R4: A pulse on `rx_evt_set` sets raw bit 4 (receive) and a pulse on `rx_evt_clr` clears it. When both pulse in the same cycle, set wins.
- R5: A write to byte 0x44 clears each raw bit where wdata has a 1 and leaves the others unchanged.
- R6: Raw status reads at byte 0x3C. Masked status at byte 0x40 reads raw AND mask. `irq` equals the OR of that AND, and it follows a mask or clear write from the next cycle.
- R7: A read of byte 0x00 returns `rx_head` in bits 11:0 and asserts `rx_pop` in that cycle. It also captures `rx_head[11:8]` into the receive status word at byte 0x04. Any write to byte 0x04 zeroes that word. No other read asserts `rx_pop`.
- R8: The flag word at byte 0x18 reads bit7=1 (transmit empty), bit6=`rx_full`, bit5=0, bit4=`rx_empty`, and writes to it are ignored.
- R9: Bytes 0xFE0 to 0xFFC read, one per word, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Unmapped words, the identification words, and the read-only status words (0x3C, 0x40) read as shown above or zero. Writes to them change no register, no raw bit and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, not asserted with `bus_wr` |
| bus_addr | input | 12 | Byte address in the window, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| rx_head | input | 12 | Receive FIFO head: error bits 11:8, data 7:0 |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_evt_set | input | 1 | Pulse: receive level reached threshold |
| rx_evt_clr | input | 1 | Pulse: receive level fell below threshold |
| rx_pop | output | 1 | Pops the receive FIFO head |
| tx_valid | output | 1 | Transmit byte valid, one cycle per data write |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
A wrong raw or mask bit shows on `irq` and on the masked status word in the cycle after the access that should have set it. A write that reaches the wrong register shows on the next read-back of that register. A stuck transmit register shows as a missing, doubled or wrong byte on the cycle after a data write. A lost capture of the error bits shows only when the receive status word is read. So the bench follows each data read with a status read, and it follows every write with read-backs of the state that the write could have disturbed.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int ADDR_W  = 12;
  localparam int WIDX_W  = ADDR_W - 2;
  localparam int RXD_W   = 8;
  localparam int RXE_W   = 4;
  localparam int RXH_W   = RXD_W + RXE_W;
  localparam int IRQ_W   = 11;
  localparam int TX_BIT  = 5;
  localparam int RX_BIT  = 4;
  localparam int CFG_W   = 16;
  localparam int NCFG    = 8;
  localparam int C_MASK  = 6;

  localparam logic [WIDX_W-1:0] W_DATA   = 10'd0;
  localparam logic [WIDX_W-1:0] W_RXSTAT = 10'd1;
  localparam logic [WIDX_W-1:0] W_FLAG   = 10'd6;
  localparam logic [WIDX_W-1:0] W_RAW    = 10'd15;
  localparam logic [WIDX_W-1:0] W_MSKD   = 10'd16;
  localparam logic [WIDX_W-1:0] W_CLEAR  = 10'd17;
  localparam logic [WIDX_W-4:0] W_IDTOP  = 7'h7F;

  // configuration words: index 7 down to 0
  localparam logic [NCFG-1:0][WIDX_W-1:0] CFG_WIDX = {
    10'd18, 10'd14, 10'd13, 10'd12, 10'd11, 10'd10, 10'd9, 10'd8};
  localparam logic [NCFG-1:0][CFG_W-1:0] CFG_MASK = {
    16'h0007, 16'h07FF, 16'h003F, 16'hFFFF, 16'h00FF, 16'h003F, 16'hFFFF, 16'h00FF};
  localparam logic [NCFG-1:0][CFG_W-1:0] CFG_RST = {
    16'h0000, 16'h0000, 16'h0012, 16'h0300, 16'h0000, 16'h0000, 16'h0000, 16'h0000};

  typedef struct packed {
    logic            data;
    logic            rxstat;
    logic            flag;
    logic            raw;
    logic            mskd;
    logic            clear;
    logic            id;
    logic [NCFG-1:0] cfg;
  } sel_t;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    id_byte = 8'h11;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
(
  input  logic [WIDX_W-1:0] widx,
  output sel_t              sel
);
  always_comb begin
    sel        = '0;
    sel.data   = (widx == W_DATA);
    sel.rxstat = (widx == W_RXSTAT);
    sel.flag   = (widx == W_FLAG);
    sel.raw    = (widx == W_RAW);
    sel.mskd   = (widx == W_MSKD);
    sel.clear  = (widx == W_CLEAR);
    sel.id     = (widx[WIDX_W-1:3] == W_IDTOP);
    for (int i = 0; i < NCFG; i++) begin
      sel.cfg[i] = (widx == CFG_WIDX[i]);
    end
  end
endmodule

// File: rtl/uart_regif_cfg.sv
module uart_regif_cfg
  import uart_regif_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCFG-1:0]            wr_sel,
  input  logic [CFG_W-1:0]           wdata,
  output logic [NCFG-1:0][CFG_W-1:0] q
);
  for (genvar i = 0; i < NCFG; i++) begin : g_reg
    logic [CFG_W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)         r <= CFG_RST[i];
      else if (wr_sel[i]) r <= wdata & CFG_MASK[i];
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
  import uart_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_set,
  input  logic             rx_set,
  input  logic             rx_clr,
  input  logic             clr_wr,
  input  logic [IRQ_W-1:0] clr_val,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] raw,
  output logic             irq
);
  logic [IRQ_W-1:0] raw_nx;

  always_comb begin
    raw_nx = raw;
    if (rx_clr) raw_nx[RX_BIT] = 1'b0;
    if (clr_wr) raw_nx = raw_nx & ~clr_val;
    if (tx_set) raw_nx[TX_BIT] = 1'b1;
    if (rx_set) raw_nx[RX_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= raw_nx;
  end

  assign irq = |(raw & mask);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [RXH_W-1:0] rx_head,
  input  logic             rx_empty,
  input  logic             rx_full,
  input  logic             rx_evt_set,
  input  logic             rx_evt_clr,
  output logic             rx_pop,
  output logic             tx_valid,
  output logic [RXD_W-1:0] tx_byte,
  output logic             irq
);
  logic [WIDX_W-1:0]          widx;
  sel_t                       sel;
  logic [NCFG-1:0][CFG_W-1:0] cfg_q;
  logic [IRQ_W-1:0]           raw_q;
  logic [IRQ_W-1:0]           mask_q;
  logic [RXE_W-1:0]           rsr_q;
  logic                       unused_bits;

  assign widx        = bus_addr[ADDR_W-1:2];
  assign mask_q      = cfg_q[C_MASK][IRQ_W-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:CFG_W], cfg_q[C_MASK][CFG_W-1:IRQ_W]};

  uart_regif_decode u_dec (
    .widx (widx),
    .sel  (sel)
  );

  uart_regif_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (sel.cfg & {NCFG{bus_wr}}),
    .wdata  (bus_wdata[CFG_W-1:0]),
    .q      (cfg_q)
  );

  uart_regif_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_set  (bus_wr & sel.data),
    .rx_set  (rx_evt_set),
    .rx_clr  (rx_evt_clr),
    .clr_wr  (bus_wr & sel.clear),
    .clr_val (bus_wdata[IRQ_W-1:0]),
    .mask    (mask_q),
    .raw     (raw_q),
    .irq     (irq)
  );

  // receive status capture and clear
  always_ff @(posedge clk) begin
    if (!rst_n)                     rsr_q <= '0;
    else if (bus_rd && sel.data)    rsr_q <= rx_head[RXH_W-1:RXD_W];
    else if (bus_wr && sel.rxstat)  rsr_q <= '0;
  end

  // transmit handoff
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= bus_wr & sel.data;
      if (bus_wr && sel.data) tx_byte <= bus_wdata[RXD_W-1:0];
    end
  end

  assign rx_pop = bus_rd & sel.data;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (sel.data)   bus_rdata[RXH_W-1:0] = rx_head;
    if (sel.rxstat) bus_rdata[RXE_W-1:0] = rsr_q;
    if (sel.flag)   bus_rdata[7:0] = {1'b1, rx_full, 1'b0, rx_empty, 4'b0000};
    if (sel.raw)    bus_rdata[IRQ_W-1:0] = raw_q;
    if (sel.mskd)   bus_rdata[IRQ_W-1:0] = raw_q & mask_q;
    if (sel.id)     bus_rdata[7:0] = id_byte(widx[2:0]);
    for (int i = 0; i < NCFG; i++) begin
      if (sel.cfg[i]) bus_rdata[CFG_W-1:0] = cfg_q[i];
    end
  end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              tx_valid,
  input logic [RXD_W-1:0]  tx_byte,
  input logic              irq,
  input logic              rx_evt_set,
  input logic [IRQ_W-1:0]  raw,
  input logic [IRQ_W-1:0]  mask,
  input logic [RXE_W-1:0]  rsr
);
  logic dwr;
  assign dwr = bus_wr && (bus_addr[ADDR_W-1:2] == W_DATA);

  assert_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dwr |=> (tx_valid && tx_byte == $past(bus_wdata[RXD_W-1:0])));

  assert_tx_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dwr |=> !tx_valid);

  assert_tx_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dwr |=> raw[TX_BIT]);

  assert_rx_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt_set |=> raw[RX_BIT]);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1:2] == W_CLEAR && !rx_evt_set)
      |=> ((raw & $past(bus_wdata[IRQ_W-1:0])) == '0));

  assert_irq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  assert_irq_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |-> !irq);

  assert_rsr_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr[ADDR_W-1:2] == W_RXSTAT) |=> (rsr == '0));
endmodule

bind uart_regif uart_regif_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .tx_valid   (tx_valid),
  .tx_byte    (tx_byte),
  .irq        (irq),
  .rx_evt_set (rx_evt_set),
  .raw        (raw_q),
  .mask       (mask_q),
  .rsr        (rsr_q)
);

// File: tb/uart_regif_test.sv
`timescale 1ns/1ps
module uart_regif_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] rx_head = '0;
  logic        rx_empty = 1'b1;
  logic        rx_full = 1'b0;
  logic        rx_evt_set = 1'b0;
  logic        rx_evt_clr = 1'b0;
  logic        rx_pop;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;

  int tests = 0;
  int fails = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  tx_q[$];

  localparam logic [7:0] ID_EXP [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #2 clk = ~clk;

  uart_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_head(rx_head), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_evt_set(rx_evt_set), .rx_evt_clr(rx_evt_clr), .rx_pop(rx_pop),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  // monitor: reads and transmit pulses, compared against the queues
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s addr=%03h got=%08h exp=%08h", t, bus_addr, bus_rdata, e);
      end
      tests++;
      if (rx_pop !== (bus_addr[11:2] == 10'd0)) begin
        fails++;
        $display("FAIL R7 rx_pop addr=%03h got=%0b exp=%0b", bus_addr, rx_pop, bus_addr[11:2] == 10'd0);
      end
    end
    if (rst_n && tx_valid) begin
      tests++;
      if (tx_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected tx pulse got=%02h exp=none", tx_byte);
      end else begin
        logic [7:0] eb;
        eb = tx_q.pop_front();
        if (tx_byte !== eb) begin
          fails++;
          $display("FAIL R3 tx byte got=%02h exp=%02h", tx_byte, eb);
        end
      end
    end
  end

  // driver tasks: each starts one time unit after an edge and spans one cycle
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a[11:2] == 10'd0) tx_q.push_back(d[7:0]);
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    tests++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq got=%0b exp=%0b", t, irq, e);
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired got=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(12'h034, 32'h12,  "R1 fifo level");
    rd(12'h030, 32'h300, "R1 control");
    rd(12'h018, 32'h90,  "R1 flags");
    rd(12'h03C, 32'h0,   "R1 raw");
    rd(12'h038, 32'h0,   "R1 mask");

    // R2 configuration write and read-back with widths
    wr(12'h020, 32'h0000_01FF); wr(12'h024, 32'hFFFF_ABCD);
    wr(12'h028, 32'h0000_00FF); wr(12'h02C, 32'h0000_1234);
    wr(12'h030, 32'h0001_2345); wr(12'h034, 32'h0000_FFFF);
    wr(12'h048, 32'h0000_000F); wr(12'h038, 32'h0000_FFFF);
    rd(12'h020, 32'hFF,   "R2 irda");
    rd(12'h024, 32'hABCD, "R2 int baud");
    rd(12'h028, 32'h3F,   "R2 frac baud");
    rd(12'h02C, 32'h34,   "R2 line");
    rd(12'h030, 32'h2345, "R2 control");
    rd(12'h034, 32'h3F,   "R2 fifo level");
    rd(12'h048, 32'h7,    "R2 dma");
    rd(12'h038, 32'h7FF,  "R2 mask");
    wr(12'h038, 32'h0);

    // R8 flags follow inputs, writes ignored
    rx_full = 1'b1; rx_empty = 1'b0;
    wr(12'h018, 32'h0);
    rd(12'h018, 32'hC0, "R8 flags full");
    rx_full = 1'b0; rx_empty = 1'b1;
    rd(12'h018, 32'h90, "R8 flags empty");

    // R3 transmit, including back-to-back
    wr(12'h000, 32'h0000_01A5);
    rd(12'h03C, 32'h20, "R3 raw tx");
    chk_irq(1'b0, "R6 masked off");
    wr(12'h000, 32'h11);
    wr(12'h000, 32'h22);
    // R6 mask enables irq next cycle
    wr(12'h038, 32'h20);
    chk_irq(1'b1, "R6 mask on");
    rd(12'h040, 32'h20, "R6 masked status");

    // R5 write-one-to-clear
    wr(12'h044, 32'h10);
    rd(12'h03C, 32'h20, "R5 other bit kept");
    wr(12'h044, 32'h20);
    rd(12'h03C, 32'h0, "R5 cleared");
    chk_irq(1'b0, "R6 after clear");

    // R4 receive events
    wr(12'h038, 32'h10);
    rx_evt_set = 1'b1; @(posedge clk); #1; rx_evt_set = 1'b0;
    chk_irq(1'b1, "R4 rx set");
    rd(12'h03C, 32'h10, "R4 raw rx");
    rx_evt_clr = 1'b1; @(posedge clk); #1; rx_evt_clr = 1'b0;
    chk_irq(1'b0, "R4 rx clr");
    rx_evt_set = 1'b1; rx_evt_clr = 1'b1; @(posedge clk); #1;
    rx_evt_set = 1'b0; rx_evt_clr = 1'b0;
    rd(12'h03C, 32'h10, "R4 set wins");
    wr(12'h044, 32'h7FF);
    rd(12'h040, 32'h0, "R5 clear all");

    // R7 data read, status capture, status clear
    rx_head = 12'h5C3;
    rd(12'h000, 32'h5C3, "R7 data");
    rx_head = 12'h0AA;
    rd(12'h004, 32'h5, "R7 status");
    wr(12'h004, 32'h0);
    rd(12'h004, 32'h0, "R7 status clear");

    // R9 identification block
    for (int k = 0; k < 8; k++) rd(12'(12'hFE0 + 4 * k), {24'h0, ID_EXP[k]}, "R9 id");

    // R10 writes to unmapped, id and read-only words
    wr(12'h008, '1); wr(12'h00C, '1); wr(12'h010, '1); wr(12'h014, '1);
    wr(12'h01C, '1); wr(12'h03C, '1); wr(12'h040, '1); wr(12'h04C, '1);
    wr(12'h400, '1); wr(12'hFE0, '1);
    chk_irq(1'b0, "R10 irq");
    rd(12'h008, 32'h0,    "R10 unmapped");
    rd(12'h04C, 32'h0,    "R10 unmapped");
    rd(12'h400, 32'h0,    "R10 unmapped");
    rd(12'h044, 32'h0,    "R10 clear word");
    rd(12'h03C, 32'h0,    "R10 raw kept");
    rd(12'h038, 32'h10,   "R10 mask kept");
    rd(12'h024, 32'hABCD, "R10 baud kept");
    rd(12'h004, 32'h0,    "R10 status kept");
    rd(12'hFE0, 32'h11,   "R10 id kept");

    idle(3);
    tests++;
    if (tx_q.size() != 0 || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 pending items got=%0d exp=0", tx_q.size() + exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule